// File: doc/BRIEF.md
# Zero-Page Data Bank Address Mapper

This block sits between an 8-bit processor's 16-bit data port and a 24-bit system bus. Accesses in the lower half of the processor's space go to the bus unchanged, with the top address byte forced to zero. Accesses in the upper half take their top byte from a bank number. Reads and writes use the same rule.

The bank number has no dedicated register. Software keeps it in one byte of ordinary zero-page RAM, at 0x00FF. The mapper watches the processor's write traffic and keeps a live copy of whatever is last written to that byte. The RAM write itself still reaches the bus as normal.

The mapper also flags upper-half accesses as ROM accesses and gives a ROM offset. That offset drops the top bus address bit, because the ROM image repeats every 8 MB. The only state is the bank copy. Every output follows its inputs in the same cycle, so no wait states are added.

Top module: `zpb_mapper`

## Requirements
- R1: When `cpu_addr` is below 0x8000, `bus_addr` equals `{8'h00, cpu_addr}` in the same cycle, and `rom_sel` is 0.
- R2: A read (`cpu_rd`=1) with `cpu_addr` at or above 0x8000 drives `bus_addr` = `{bank, cpu_addr}` in the same cycle, where bank is the current shadow value.
- R3: A write (`cpu_wr`=1) with `cpu_addr` at or above 0x8000 uses the same rule as R2, and `bus_wdata` carries `cpu_wdata` unchanged.
- R4: A write to address 0x00FF loads `cpu_wdata` into the shadow bank at that clock edge. That write is presented on the bus as a plain low-half access. Every upper-half access from the next cycle on uses the new bank, including one in the very next cycle.
- R5: A synchronous active-low reset (`rst_n`=0 at a rising edge) sets the shadow bank to 0x00. An upper-half access after reset therefore maps to `{8'h00, cpu_addr}`.
- R6: The shadow bank is left unchanged by reads of 0x00FF, by writes to any other address (including 0x00FE, 0x01FF and the upper-half 0x80FF), and by idle cycles.
- R7: `rom_sel` is 1 exactly when a read or write targets `cpu_addr` at or above 0x8000. `rom_addr` is `bus_addr[22:0]`, so banks that differ only in bit 7 give the same ROM offset.
- R8: `bus_rd` and `bus_wr` equal `cpu_rd` and `cpu_wr` in the same cycle; the mapper adds no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Processor data address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| bus_addr | output | 24 | Mapped system bus address |
| bus_wdata | output | 8 | Write data to the bus |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| rom_sel | output | 1 | Access targets the banked ROM window |
| rom_addr | output | 23 | ROM offset, with the mirror bit removed |

## Verification
The assertions assume that `cpu_rd` and `cpu_wr` are never high together. They also assume that the address, data and strobes are stable around each rising edge, since the bank copy is taken from whatever write is present at the edge.

The bench drives every access on the falling edge and holds it for one full cycle. It never raises both strobes at once. It keeps the strobes low while reset is applied.

Bank-changing writes are placed directly before upper-half accesses. This exercises the one-cycle hand-off, alongside the writes that must leave the bank alone.

// File: rtl/zpb_pkg.sv
// Package: shared types and helpers for the zero-page bank mapper.
// Assumes a processor data port narrower than the system bus address.
package zpb_pkg;

    // Kind of processor access present in a cycle.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_BAD   = 2'b11
    } acc_kind_t;

    // Encodes the two strobes into an access kind.
    function automatic acc_kind_t acc_kind(input logic rd, input logic wr);
        return acc_kind_t'({wr, rd});
    endfunction

    // True when the kind is a real bus transfer.
    function automatic logic acc_active(input acc_kind_t k);
        return (k == ACC_READ) || (k == ACC_WRITE);
    endfunction

endpackage

// File: rtl/zpb_bank_shadow.sv
// Module: zpb_bank_shadow
// Keeps a copy of the bank byte by watching processor writes to one
// fixed RAM address. It does not intercept the write; the bus still sees it.
// Assumes: write strobe and data are stable at the rising edge.
module zpb_bank_shadow #(
    parameter int CPU_AW   = 16,
    parameter int DW       = 8,
    parameter int BW       = 8,
    parameter logic [CPU_AW-1:0] BANK_LOC = 16'h00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    input  logic              cpu_wr,
    output logic [BW-1:0]     bank_q
);

    logic          hit_wr;
    logic [BW-1:0] wr_bank;

    // Detect a write to the bank byte location.
    always_comb hit_wr = cpu_wr && (cpu_addr == BANK_LOC);

    // Fit the data byte to the bank width.
    generate
        if (BW == DW) begin : g_same
            always_comb wr_bank = cpu_wdata;
        end else if (BW < DW) begin : g_narrow
            always_comb wr_bank = cpu_wdata[BW-1:0];
        end else begin : g_wide
            always_comb wr_bank = {{(BW-DW){1'b0}}, cpu_wdata};
        end
    endgenerate

    // Shadow register: cleared by reset, loaded on a snooped write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (hit_wr) begin
            bank_q <= wr_bank;
        end
    end

endmodule

// File: rtl/zpb_addr_map.sv
// Module: zpb_addr_map
// Pure combinational translation of a processor address to a bus address.
// Below the split point the upper bits are zero; at or above it they come
// from the bank. Assumes BUS_AW = CPU_AW + BW.
module zpb_addr_map #(
    parameter int CPU_AW = 16,
    parameter int BW     = 8,
    parameter int BUS_AW = CPU_AW + BW,
    parameter logic [CPU_AW-1:0] SPLIT = 16'h8000
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [BW-1:0]     bank,
    output logic              upper,
    output logic [BUS_AW-1:0] bus_addr
);

    // Classify the address half.
    always_comb upper = (cpu_addr >= SPLIT);

    // Build the bus address from the half classification.
    always_comb begin
        if (upper) begin
            bus_addr = {bank, cpu_addr};
        end else begin
            bus_addr = {{BW{1'b0}}, cpu_addr};
        end
    end

endmodule

// File: rtl/zpb_rom_window.sv
// Module: zpb_rom_window
// Flags active upper-half accesses as ROM accesses and gives the ROM
// offset. The top bus bit is a mirror bit and is not passed in.
// Assumes the ROM fills the whole banked upper half.
module zpb_rom_window #(
    parameter int OFF_W = 23
) (
    input  logic             upper,
    input  logic             active,
    input  logic [OFF_W-1:0] bus_low,
    output logic             rom_sel,
    output logic [OFF_W-1:0] rom_addr
);

    // Select the ROM only for a real transfer in the banked half.
    always_comb rom_sel = upper && active;

    // The offset is the bus address with the mirror bit already removed.
    always_comb rom_addr = bus_low;

endmodule

// File: rtl/zpb_mapper.sv
// Module: zpb_mapper (top)
// Maps 16-bit processor data accesses onto a 24-bit bus. The bank byte is
// a snooped copy of a zero-page RAM location. Only the shadow is registered;
// all bus outputs follow the inputs in the same cycle.
// Assumes read and write strobes are mutually exclusive.
module zpb_mapper #(
    parameter int CPU_AW = 16,
    parameter int DW     = 8,
    parameter int BUS_AW = 24,
    parameter logic [CPU_AW-1:0] BANK_LOC = 16'h00FF,
    parameter logic [CPU_AW-1:0] SPLIT    = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [DW-1:0]     bus_wdata,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              rom_sel,
    output logic [BUS_AW-2:0] rom_addr
);
    import zpb_pkg::*;

    localparam int BW    = BUS_AW - CPU_AW;
    localparam int OFF_W = BUS_AW - 1;

    logic [BW-1:0]     bank_cur;
    logic              upper_w;
    logic [BUS_AW-1:0] bus_addr_w;
    acc_kind_t         kind;
    logic              active;

    // Classify the access from the two strobes.
    always_comb kind   = acc_kind(cpu_rd, cpu_wr);
    always_comb active = acc_active(kind);

    zpb_bank_shadow #(
        .CPU_AW  (CPU_AW),
        .DW      (DW),
        .BW      (BW),
        .BANK_LOC(BANK_LOC)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_wr   (cpu_wr),
        .bank_q   (bank_cur)
    );

    zpb_addr_map #(
        .CPU_AW(CPU_AW),
        .BW    (BW),
        .BUS_AW(BUS_AW),
        .SPLIT (SPLIT)
    ) u_map (
        .cpu_addr(cpu_addr),
        .bank    (bank_cur),
        .upper   (upper_w),
        .bus_addr(bus_addr_w)
    );

    zpb_rom_window #(
        .OFF_W(OFF_W)
    ) u_rom (
        .upper   (upper_w),
        .active  (active),
        .bus_low (bus_addr_w[OFF_W-1:0]),
        .rom_sel (rom_sel),
        .rom_addr(rom_addr)
    );

    // Bus request: mapped address plus the strobes and data, unbuffered.
    always_comb begin
        bus_addr  = bus_addr_w;
        bus_wdata = cpu_wdata;
        bus_rd    = cpu_rd;
        bus_wr    = cpu_wr;
    end

endmodule

// File: rtl/zpb_mapper_chk.sv
// Module: zpb_mapper_chk
// Checker attached to zpb_mapper. It relates the processor side, the bus
// side and the shadow bank over time.
module zpb_mapper_chk #(
    parameter int CPU_AW = 16,
    parameter int DW     = 8,
    parameter int BUS_AW = 24,
    parameter logic [CPU_AW-1:0] BANK_LOC = 16'h00FF,
    parameter logic [CPU_AW-1:0] SPLIT    = 16'h8000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic [DW-1:0]     cpu_wdata,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              rom_sel,
    input logic [BUS_AW-2:0] rom_addr,
    input logic [BUS_AW-CPU_AW-1:0] bank_cur
);
    localparam int BW = BUS_AW - CPU_AW;

    // R1: the lower half maps with a zero upper byte, and never to ROM
    a_r1_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < SPLIT) |-> (bus_addr == {{BW{1'b0}}, cpu_addr} && !rom_sel));

    // R2: an upper-half read takes the shadow bank
    a_r2_read_banked: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr >= SPLIT) |-> (bus_addr == {bank_cur, cpu_addr}));

    // R3: an upper-half write uses the same rule and passes the data through
    a_r3_write_banked: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr >= SPLIT) |-> (bus_addr == {bank_cur, cpu_addr} && bus_wdata == cpu_wdata));

    // R4: a write to the bank byte is seen in the next cycle
    a_r4_snoop_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == BANK_LOC) |=> (bank_cur == $past(cpu_wdata[BW-1:0])));

    // R5: reset clears the shadow bank
    a_r5_reset_clears_bank: assert property (@(posedge clk)
        (!rst_n) |=> (bank_cur == '0));

    // R6: any cycle other than a write to the bank byte leaves the bank alone
    a_r6_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr == BANK_LOC) |=> $stable(bank_cur));

    // R7: ROM select follows active upper-half access; offset tracks the processor address
    a_r7_rom_sel: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel == ((cpu_rd || cpu_wr) && cpu_addr >= SPLIT));
    a_r7_rom_offset: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (rom_addr[CPU_AW-1:0] == cpu_addr
                     && rom_addr[BUS_AW-2:CPU_AW] == bank_cur[BW-2:0]));

    // R8: strobes pass through with no wait state
    a_r8_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd == cpu_rd) && (bus_wr == cpu_wr));

    // R8: input assumption that the strobes are exclusive
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_rd, cpu_wr}));

endmodule

bind zpb_mapper zpb_mapper_chk #(
    .CPU_AW  (CPU_AW),
    .DW      (DW),
    .BUS_AW  (BUS_AW),
    .BANK_LOC(BANK_LOC),
    .SPLIT   (SPLIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_wdata(cpu_wdata),
    .cpu_rd   (cpu_rd),
    .cpu_wr   (cpu_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .rom_sel  (rom_sel),
    .rom_addr (rom_addr),
    .bank_cur (bank_cur)
);

// File: tb/sim_zpb_mapper.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected bus requests into a queue,
// and the monitor pops and compares them late in each cycle.
module sim_zpb_mapper;

    typedef struct packed {
        logic [23:0] addr;
        logic [7:0]  wdata;
        logic        rd;
        logic        wr;
        logic        rsel;
        logic [22:0] roff;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [23:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_rd;
    logic        bus_wr;
    logic        rom_sel;
    logic [22:0] rom_addr;

    int   n_chk  = 0;
    int   n_fail = 0;
    logic [7:0] model_bank = 8'h00;
    exp_t  exp_q[$];
    string tag_q[$];
    logic  done = 1'b0;

    always #2.5 clk = ~clk;

    zpb_mapper u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .rom_sel(rom_sel), .rom_addr(rom_addr)
    );

    // Driver: present one access for one cycle and queue what the bus must show.
    task automatic access(input logic [15:0] a, input logic [7:0] d,
                          input logic rd, input logic wr, input string tag);
        exp_t e;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_rd = rd; cpu_wr = wr;
        e.addr  = (a >= 16'h8000) ? {model_bank, a} : {8'h00, a};
        e.wdata = d;
        e.rd    = rd;
        e.wr    = wr;
        e.rsel  = (a >= 16'h8000) && (rd || wr);
        e.roff  = e.addr[22:0];
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (wr && a == 16'h00FF) model_bank = d;
    endtask

    // Apply synchronous reset for one edge with the strobes low.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_bank = 8'h00;
    endtask

    // Monitor: compare queued expectations before the next rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() != 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (bus_addr !== e.addr || bus_wdata !== e.wdata || bus_rd !== e.rd ||
                    bus_wr !== e.wr || rom_sel !== e.rsel || rom_addr !== e.roff) begin
                    n_fail++;
                    $display("FAIL %s: got addr=%h wd=%h rd=%b wr=%b rsel=%b roff=%h exp addr=%h wd=%h rd=%b wr=%b rsel=%b roff=%h",
                             t, bus_addr, bus_wdata, bus_rd, bus_wr, rom_sel, rom_addr,
                             e.addr, e.wdata, e.rd, e.wr, e.rsel, e.roff);
                end
            end
        end
    end

    // Watchdog: end a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        access(16'h1234, 8'h00, 1'b1, 1'b0, "R1 low read");
        access(16'h7FFF, 8'h9A, 1'b0, 1'b1, "R1 low write top");
        access(16'h8000, 8'h00, 1'b1, 1'b0, "R5 reset bank zero");
        access(16'h00FF, 8'h3C, 1'b0, 1'b1, "R4 bank write seen low");
        access(16'hABCD, 8'h00, 1'b1, 1'b0, "R4 next-cycle bank use");
        access(16'hFFFF, 8'h11, 1'b0, 1'b1, "R3 banked write");
        access(16'h00FF, 8'h00, 1'b1, 1'b0, "R6 read of bank byte");
        access(16'h00FE, 8'h77, 1'b0, 1'b1, "R6 write neighbour low");
        access(16'h01FF, 8'h66, 1'b0, 1'b1, "R6 write 01FF");
        access(16'h80FF, 8'h55, 1'b0, 1'b1, "R6 write 80FF");
        access(16'hC000, 8'h00, 1'b0, 1'b0, "R7 idle upper no rom_sel");
        access(16'h8001, 8'h00, 1'b1, 1'b0, "R6 bank kept 3C");
        access(16'h00FF, 8'h85, 1'b0, 1'b1, "R4 bank 85");
        access(16'h9000, 8'h00, 1'b1, 1'b0, "R7 mirror high bank");
        access(16'h00FF, 8'h05, 1'b0, 1'b1, "R4 bank 05");
        access(16'h9000, 8'h00, 1'b1, 1'b0, "R7 mirror low bank");
        access(16'h9000, 8'h00, 1'b0, 1'b1, "R8 write strobe pass");
        for (int i = 0; i < 8; i++) begin
            access(16'h00FF, 8'(i * 37 + 1), 1'b0, 1'b1, "R4 sweep load");
            access(16'(16'h8000 + i * 16'h0F11), 8'(i), 1'(i % 2), 1'(1 - i % 2), "R2 sweep banked");
        end
        access(16'h00FF, 8'h20, 1'b0, 1'b1, "R4 bank 20");
        access(16'hE000, 8'h00, 1'b1, 1'b0, "R2 bank 20 read");
        do_reset();
        access(16'hC000, 8'h00, 1'b1, 1'b0, "R5 reset mid-run");
        access(16'h0000, 8'h00, 1'b0, 1'b0, "R8 idle strobes low");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule